// File: doc/BRIEF.md
# Resource Fault Isolation Accumulator

This block narrows down which physical resource in a grid of `ROWS` x `COLS` resources is faulty. It does so by comparing the resource-usage maps of many configurations. Each configuration is delivered as `ROWS` beats, one row of its usage bitmap per beat, where a 1 means the configuration occupies that resource. A flag travels with each beat and says whether that configuration's output disagreed with its competitor.

On a disagreeing beat, the block adds one to a saturating history counter for every used resource. It also keeps only the used resources in its candidate set. On an agreeing beat, the history is untouched, but every resource the configuration used is cleared from the candidate set, because those resources have just proven themselves.

The result is computed by a row-serial scan that runs in lockstep with the incoming rows, so configurations may follow back to back. The scan yields three things:
- the number of remaining candidates;
- the grid position and value of the largest history count;
- an isolation flag when exactly one candidate is left.

A synchronous clear starts a new isolation campaign.

Top module: `resource_fault_locator`

## Requirements
- R1: After reset, the history is all zero and every resource is a candidate. `cand_count` reads `ROWS*COLS`, `max_count` reads 0 at row 0, column 0, and `isolated` and `result_valid` read 0.
- R2: A configuration is `ROWS` beats with `row_valid` high, taken row 0 first. The row position advances only on beats, so idle cycles between beats do not change the result.
- R3: On a beat with `discrepant` = 1, each history counter of that row whose `row_use` bit is 1 grows by one, saturating at 2^`CNT_W`-1 (15 by default). History counts never decrease except through clear or reset.
- R4: On a beat with `discrepant` = 0, the history is unchanged, and each candidate whose `row_use` bit (bit c = column c) is 1 is removed.
- R5: On a beat with `discrepant` = 1, each candidate whose `row_use` bit is 0 is removed, so the candidate set is intersected with the usage map. The candidate count never grows except through clear or reset.
- R6: `result_valid` is high for exactly one cycle, in the cycle after the edge that takes the last row. All result outputs keep their values until the next such pulse or a clear.
- R7: `max_count`, `max_row` and `max_col` give the largest history count over the whole grid. Ties go to the lowest row, then the lowest column.
- R8: `cand_count` is the number of remaining candidates, and `isolated` is 1 exactly when it equals one.
- R9: `clr` is synchronous and wins over a beat in the same cycle. It returns the history, the candidate set, the row position and all outputs to the R1 state, so a partly delivered configuration is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of history, candidates and row position |
| row_valid | input | 1 | A usage row is present this cycle |
| row_use | input | COLS | Usage bits of the current row, bit c = column c |
| discrepant | input | 1 | The configuration being delivered disagreed |
| result_valid | output | 1 | One-cycle pulse: results of the last configuration are new |
| cand_count | output | $clog2(ROWS*COLS+1) | Number of remaining candidates |
| max_row | output | $clog2(ROWS) | Row of the highest history count |
| max_col | output | $clog2(COLS) | Column of the highest history count |
| max_count | output | CNT_W | Highest history count |
| isolated | output | 1 | Exactly one candidate remains |

## Verification
Every result is due one cycle after the edge that takes the final row of a configuration. The history and candidate updates of that row are folded into the scan combinationally, so there is no extra latency. A clear shows its effect one cycle after its edge.

The bench drives each beat half a period before the edge and reads the outputs at the falling edge that follows the last row. It checks there that `result_valid` is set. It then reads again one cycle later to confirm that the pulse has dropped and the results are held. Expected values come from a grid model in the bench that applies R3 to R5 row by row and scans in the R7 order.

// File: rtl/fault_loc_pkg.sv
// Package: shared types of the resource fault locator.
// Assumes nothing beyond IEEE 1800-2017.
package fault_loc_pkg;

    // Verdict carried with each usage row.
    typedef enum logic {
        VERDICT_AGREE      = 1'b0,
        VERDICT_DISCREPANT = 1'b1
    } verdict_e;

endpackage

// File: rtl/fault_loc_row_update.sv
// Module: fault_loc_row_update
// Computes the next history counters and candidate bits of one grid row from
// its current state, the usage bits and the verdict. Purely combinational;
// assumes the caller writes the results back only on a valid beat.
module fault_loc_row_update
    import fault_loc_pkg::*;
#(
    parameter int COLS  = 10,
    parameter int CNT_W = 4
) (
    input  logic [COLS-1:0][CNT_W-1:0] hist_cur,
    input  logic [COLS-1:0]            cand_cur,
    input  logic [COLS-1:0]            use_bits,
    input  verdict_e                   verdict,
    output logic [COLS-1:0][CNT_W-1:0] hist_nxt,
    output logic [COLS-1:0]            cand_nxt
);

    generate
        for (genvar c = 0; c < COLS; c++) begin : g_col
            // Saturating increment of a used cell on a discrepant verdict.
            always_comb begin
                if (verdict == VERDICT_DISCREPANT && use_bits[c] &&
                    hist_cur[c] != {CNT_W{1'b1}})
                    hist_nxt[c] = hist_cur[c] + 1'b1;
                else
                    hist_nxt[c] = hist_cur[c];
            end

            // Intersect with usage on discrepancy, exonerate used cells otherwise.
            always_comb begin
                if (verdict == VERDICT_DISCREPANT)
                    cand_nxt[c] = cand_cur[c] & use_bits[c];
                else
                    cand_nxt[c] = cand_cur[c] & ~use_bits[c];
            end
        end
    endgenerate

endmodule

// File: rtl/fault_loc_row_scan.sv
// Module: fault_loc_row_scan
// Reduces one updated row to its candidate population, its largest history
// count and the lowest column holding that count. Combinational; COLS >= 2.
module fault_loc_row_scan #(
    parameter int COLS  = 10,
    parameter int CNT_W = 4,
    localparam int CW   = $clog2(COLS),
    localparam int PW   = $clog2(COLS + 1)
) (
    input  logic [COLS-1:0][CNT_W-1:0] hist_row,
    input  logic [COLS-1:0]            cand_row,
    output logic [CNT_W-1:0]           row_max,
    output logic [CW-1:0]              row_col,
    output logic [PW-1:0]              row_pop
);

    // Strict comparison keeps the lowest column on ties.
    always_comb begin
        row_max = hist_row[0];
        row_col = '0;
        for (int c = 1; c < COLS; c++) begin
            if (hist_row[c] > row_max) begin
                row_max = hist_row[c];
                row_col = CW'(c);
            end
        end
    end

    // Population count of the surviving candidates in this row.
    always_comb begin
        row_pop = '0;
        for (int c = 0; c < COLS; c++)
            row_pop = row_pop + {{(PW-1){1'b0}}, cand_row[c]};
    end

endmodule

// File: rtl/resource_fault_locator.sv
// Module: resource_fault_locator (top)
// Holds the history matrix and candidate mask, applies one usage row per
// valid beat and folds the updated row into a running scan, publishing the
// scan when the last row of a configuration is taken. Assumes ROWS, COLS >= 2
// and that the discrepancy flag is held for all rows of one configuration.
module resource_fault_locator
    import fault_loc_pkg::*;
#(
    parameter int ROWS  = 10,
    parameter int COLS  = 10,
    parameter int CNT_W = 4,
    localparam int RW   = $clog2(ROWS),
    localparam int CW   = $clog2(COLS),
    localparam int NW   = $clog2(ROWS*COLS + 1),
    localparam int PW   = $clog2(COLS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             row_valid,
    input  logic [COLS-1:0]  row_use,
    input  logic             discrepant,
    output logic             result_valid,
    output logic [NW-1:0]    cand_count,
    output logic [RW-1:0]    max_row,
    output logic [CW-1:0]    max_col,
    output logic [CNT_W-1:0] max_count,
    output logic             isolated
);

    logic [COLS-1:0][CNT_W-1:0] hist_q [ROWS];
    logic [COLS-1:0]            cand_q [ROWS];
    logic [RW-1:0]              row_q;

    logic [COLS-1:0][CNT_W-1:0] hist_new;
    logic [COLS-1:0]            cand_new;
    logic [CNT_W-1:0]           rmax;
    logic [CW-1:0]              rcol;
    logic [PW-1:0]              rpop;

    logic [CNT_W-1:0] acc_max_q, nx_max;
    logic [RW-1:0]    acc_row_q, nx_row;
    logic [CW-1:0]    acc_col_q, nx_col;
    logic [NW-1:0]    acc_cnt_q, nx_cnt;
    logic             last_row;

    verdict_e verdict;
    assign verdict  = discrepant ? VERDICT_DISCREPANT : VERDICT_AGREE;
    assign last_row = (row_q == RW'(ROWS - 1));

    fault_loc_row_update #(.COLS(COLS), .CNT_W(CNT_W)) u_update (
        .hist_cur (hist_q[row_q]),
        .cand_cur (cand_q[row_q]),
        .use_bits (row_use),
        .verdict  (verdict),
        .hist_nxt (hist_new),
        .cand_nxt (cand_new)
    );

    fault_loc_row_scan #(.COLS(COLS), .CNT_W(CNT_W)) u_scan (
        .hist_row (hist_new),
        .cand_row (cand_new),
        .row_max  (rmax),
        .row_col  (rcol),
        .row_pop  (rpop)
    );

    // Merge this row into the running scan; earlier rows win ties.
    always_comb begin
        if (row_q == '0 || rmax > acc_max_q) begin
            nx_max = rmax;
            nx_row = row_q;
            nx_col = rcol;
        end else begin
            nx_max = acc_max_q;
            nx_row = acc_row_q;
            nx_col = acc_col_q;
        end
        nx_cnt = (row_q == '0) ? NW'(rpop) : acc_cnt_q + NW'(rpop);
    end

    // State, running scan and published results.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int r = 0; r < ROWS; r++) begin
                hist_q[r] <= '0;
                cand_q[r] <= '1;
            end
            row_q        <= '0;
            acc_max_q    <= '0;
            acc_row_q    <= '0;
            acc_col_q    <= '0;
            acc_cnt_q    <= '0;
            result_valid <= 1'b0;
            cand_count   <= NW'(ROWS*COLS);
            max_row      <= '0;
            max_col      <= '0;
            max_count    <= '0;
            isolated     <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            if (row_valid) begin
                hist_q[row_q] <= hist_new;
                cand_q[row_q] <= cand_new;
                acc_max_q     <= nx_max;
                acc_row_q     <= nx_row;
                acc_col_q     <= nx_col;
                acc_cnt_q     <= nx_cnt;
                if (last_row) begin
                    row_q        <= '0;
                    result_valid <= 1'b1;
                    cand_count   <= nx_cnt;
                    max_row      <= nx_row;
                    max_col      <= nx_col;
                    max_count    <= nx_max;
                    isolated     <= (nx_cnt == NW'(1));
                end else begin
                    row_q <= row_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fault_loc_checker.sv
// Module: fault_loc_checker
// Temporal properties of the locator's outputs, bound to every instance.
// Assumes the same parameters as the bound top.
module fault_loc_checker #(
    parameter int ROWS  = 10,
    parameter int COLS  = 10,
    parameter int CNT_W = 4,
    localparam int RW   = $clog2(ROWS),
    localparam int CW   = $clog2(COLS),
    localparam int NW   = $clog2(ROWS*COLS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             row_valid,
    input logic             result_valid,
    input logic [NW-1:0]    cand_count,
    input logic [CNT_W-1:0] max_count,
    input logic             isolated
);

    logic [NW-1:0]    prev_cnt;
    logic [CNT_W-1:0] prev_max;

    // Remember the last published count and maximum of this campaign.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prev_cnt <= NW'(ROWS*COLS);
            prev_max <= '0;
        end else if (result_valid) begin
            prev_cnt <= cand_count;
            prev_max <= max_count;
        end
    end

    a_r5_count_never_grows: assert property (@(posedge clk) disable iff (!rst_n || clr)
        result_valid |-> cand_count <= prev_cnt);

    a_r3_max_never_drops: assert property (@(posedge clk) disable iff (!rst_n || clr)
        result_valid |-> max_count >= prev_max);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    a_r6_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(row_valid));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (!result_valid && !$past(clr)) |-> ($stable(cand_count) && $stable(max_count)));

    a_r8_isolated_flag: assert property (@(posedge clk) disable iff (!rst_n)
        isolated == (cand_count == NW'(1)));

    a_r9_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cand_count == NW'(ROWS*COLS) && max_count == '0 && !isolated && !result_valid));

endmodule

bind resource_fault_locator fault_loc_checker #(
    .ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .row_valid(row_valid),
    .result_valid(result_valid), .cand_count(cand_count),
    .max_count(max_count), .isolated(isolated)
);

// File: tb/resource_fault_locator_test.sv
// Bench: directed scenarios against a grid model of the requirements.
module resource_fault_locator_test;

    localparam int ROWS  = 10;
    localparam int COLS  = 10;
    localparam int CNT_W = 4;
    localparam int RW    = $clog2(ROWS);
    localparam int CW    = $clog2(COLS);
    localparam int NW    = $clog2(ROWS*COLS + 1);
    localparam int SAT   = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr = 1'b0;
    logic             row_valid = 1'b0;
    logic [COLS-1:0]  row_use = '0;
    logic             discrepant = 1'b0;
    logic             result_valid;
    logic [NW-1:0]    cand_count;
    logic [RW-1:0]    max_row;
    logic [CW-1:0]    max_col;
    logic [CNT_W-1:0] max_count;
    logic             isolated;

    int checks = 0;
    int fails  = 0;

    int               m_hist [ROWS][COLS];
    bit               m_cand [ROWS][COLS];
    logic [COLS-1:0]  umap [ROWS];

    always #5 clk = ~clk;

    resource_fault_locator #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .row_valid(row_valid),
        .row_use(row_use), .discrepant(discrepant), .result_valid(result_valid),
        .cand_count(cand_count), .max_row(max_row), .max_col(max_col),
        .max_count(max_count), .isolated(isolated)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                m_hist[r][c] = 0;
                m_cand[r][c] = 1'b1;
            end
    endtask

    task automatic map_clear();
        for (int r = 0; r < ROWS; r++) umap[r] = '0;
    endtask

    // Compare published outputs with the model's scan.
    task automatic check_results(input string req);
        int n = 0, mx = 0, mr = 0, mc = 0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                if (m_cand[r][c]) n++;
                if (m_hist[r][c] > mx) begin
                    mx = m_hist[r][c]; mr = r; mc = c;
                end
            end
        check(req, int'(cand_count), n, "cand_count");
        check("R8", int'(isolated), (n == 1) ? 1 : 0, "isolated");
        check("R7", int'(max_count), mx, "max_count");
        check("R7", int'(max_row), mr, "max_row");
        check("R7", int'(max_col), mc, "max_col");
    endtask

    // Deliver umap as one configuration; gap inserts idle cycles between beats.
    task automatic send_config(input bit disc, input int gap);
        for (int r = 0; r < ROWS; r++) begin
            @(negedge clk);
            row_valid  = 1'b1;
            row_use    = umap[r];
            discrepant = disc;
            for (int c = 0; c < COLS; c++) begin
                if (disc && umap[r][c] && m_hist[r][c] < SAT) m_hist[r][c]++;
                m_cand[r][c] = disc ? (m_cand[r][c] & umap[r][c]) : (m_cand[r][c] & ~umap[r][c]);
            end
            if (gap > 0 && r != ROWS-1) begin
                @(negedge clk);
                row_valid = 1'b0;
                repeat (gap - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        row_valid = 1'b0;
        check("R6", int'(result_valid), 1, "result_valid after last row");
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        model_clear();
    endtask

    task automatic t_reset();
        check("R1", int'(result_valid), 0, "result_valid at reset");
        check_results("R1");
    endtask

    task automatic t_intersection();
        map_clear();
        umap[3][3] = 1'b1; umap[1][4] = 1'b1; umap[5][2] = 1'b1; umap[7][7] = 1'b1;
        send_config(1'b1, 0);
        check_results("R5");
        check("R3", int'(max_count), 1, "first count");
        map_clear();
        umap[3][3] = 1'b1; umap[2][2] = 1'b1; umap[4][5] = 1'b1; umap[1][6] = 1'b1;
        send_config(1'b1, 0);
        check_results("R5");
        check("R8", int'(isolated), 1, "single shared cell isolated");
        check("R7", int'(max_row) * 16 + int'(max_col), 3 * 16 + 3, "faulty cell position");
        check("R3", int'(max_count), 2, "shared cell count");
        @(negedge clk);
        check("R6", int'(result_valid), 0, "pulse dropped");
        check("R6", int'(cand_count), 1, "count held");
    endtask

    task automatic t_agree();
        do_clear();
        check_results("R9");
        map_clear();
        for (int c = 0; c < COLS; c++) umap[0][c] = 1'b1;
        umap[6][1] = 1'b1;
        send_config(1'b0, 0);
        check_results("R4");
        check("R4", int'(max_count), 0, "agreeing leaves history");
        check("R4", int'(cand_count), ROWS*COLS - COLS - 1, "used cells exonerated");
    endtask

    task automatic t_saturate();
        do_clear();
        map_clear();
        umap[1][2] = 1'b1;
        for (int k = 0; k < SAT + 3; k++) send_config(1'b1, 0);
        check_results("R3");
        check("R3", int'(max_count), SAT, "saturated count");
    endtask

    task automatic t_tie_with_gaps();
        do_clear();
        map_clear();
        umap[2][5] = 1'b1; umap[2][1] = 1'b1; umap[7][0] = 1'b1;
        send_config(1'b1, 2);
        check_results("R2");
        check("R7", int'(max_row) * 16 + int'(max_col), 2 * 16 + 1, "tie lowest index");
        map_clear();
        umap[9][9] = 1'b1; umap[7][0] = 1'b1;
        send_config(1'b1, 1);
        check_results("R2");
        check("R7", int'(max_row) * 16 + int'(max_col), 7 * 16 + 0, "row 7 leads");
    endtask

    task automatic t_disjoint();
        do_clear();
        map_clear();
        umap[0][0] = 1'b1;
        send_config(1'b1, 0);
        map_clear();
        umap[9][9] = 1'b1;
        send_config(1'b1, 0);
        check_results("R5");
        check("R8", int'(isolated), 0, "no candidate left");
    endtask

    task automatic t_clear_mid();
        map_clear();
        umap[4][4] = 1'b1;
        send_config(1'b1, 0);
        for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            row_valid = 1'b1; row_use = '1; discrepant = 1'b1;
        end
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0; row_valid = 1'b0;
        model_clear();
        check_results("R9");
        map_clear();
        umap[8][6] = 1'b1; umap[0][3] = 1'b1;
        send_config(1'b1, 0);
        check_results("R9");
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_intersection();
        t_agree();
        t_saturate();
        t_tie_with_gaps();
        t_disjoint();
        t_clear_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule